// File: doc/BRIEF.md
# PWM Duty Dithering Unit

This block sits between a high-precision brightness value and the PWM comparator. Its input duty word carries an integer part and up to four fractional bits. Once per PWM period it hands the comparator an integer duty. Across a frame of 2^d periods, where d is the programmed dither depth, some of those periods get one extra LSB. The number of extended periods in a frame equals the fractional value, so the average duty over the frame matches the extended input.

A period-start strobe advances an internal frame position. The position is bit-reversed and compared against the fractional value, which spreads the extended periods evenly through the frame and avoids bunching them at its start.

Dithering can be limited to brightness ramps, or enabled at constant brightness as well. When dithering is off, the fractional bits are dropped. An extension that would pass full scale is suppressed.

Top module: `pwm_dither_unit`

## Requirements
- R1: After synchronous reset, `duty_out` is 0 and the frame position is 0, so the first strobe after reset uses position 0.
- R2: `duty_out` takes a new value only in the cycle after a clock edge that sees `period_start` high. At every other edge it holds its value, even when `duty_ext` changes.
- R3: Each value loaded into `duty_out` is I or I+1, where I = `duty_ext[INT_W+FRAC_W-1:FRAC_W]` sampled at the strobe.
- R4: The effective depth is d = min(`dither_depth`, FRAC_W). The fraction used is F = the top d bits of `duty_ext[FRAC_W-1:0]`. Over 2^d consecutive strobes starting at position 0, exactly F periods are extended.
- R5: The period at frame position p is extended when F is greater than the d-bit bit-reversal of p. With d=1 and F=1, positions 0 and 2 of a run are extended, which is every second pulse. With d=4 and F=5, positions 0, 2, 4, 8 and 12 are extended.
- R6: With d=3 and F=1, exactly one pulse in every 8 is extended, and that pulse is the one at position 0.
- R7: Depth settings 5, 6 and 7 behave exactly as depth 4.
- R8: With depth 0, `duty_out` equals I at every strobe, whatever the fractional bits are.
- R9: With `steady_dither_en`=0, dithering is applied only while `ramping`=1. With both low, `duty_out` equals I.
- R10: With `steady_dither_en`=1, dithering is applied whatever the value of `ramping`.
- R11: When I is all ones (full scale), `duty_out` stays at full scale and is never extended.
- R12: The frame position advances only on a strobe and wraps to 0 after 2^d - 1. Idle cycles between strobes do not change the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_ext | input | INT_W+FRAC_W | Extended duty: integer part above, fractional bits below |
| period_start | input | 1 | One-cycle strobe at the start of each PWM period |
| dither_depth | input | DEPTH_W | Requested dither depth in bits (values above FRAC_W are clamped) |
| steady_dither_en | input | 1 | Allow dithering at constant brightness |
| ramping | input | 1 | Brightness is currently on a slope |
| duty_out | output | INT_W | Integer duty for the current period |

## Verification
The assertions check on every cycle that the output only moves after a strobe and that each loaded value is the integer part or one above it. They also check that full scale is never exceeded, that gated-off or zero-depth operation passes the integer part through, and that the frame position holds between strobes and stays inside the frame mask. Only the bench's scenarios can show frame-level behaviour: the exact count of extended periods per frame, their placement by bit-reversed position, the clamping of oversize depth settings, and the one-in-eight pattern.

// File: rtl/pwm_dither_pkg.sv
package pwm_dither_pkg;

    localparam int DEF_INT_W   = 10;
    localparam int DEF_FRAC_W  = 4;
    localparam int DEF_DEPTH_W = 3;

    // Why dithering is (or is not) active for the coming period
    typedef enum logic [1:0] {
        GATE_OFF    = 2'd0,
        GATE_RAMP   = 2'd1,
        GATE_STEADY = 2'd2
    } gate_e;

    function automatic int clamp_depth(int req, int max_depth);
        return (req > max_depth) ? max_depth : req;
    endfunction

endpackage

// File: rtl/pwm_dither_cfg.sv
module pwm_dither_cfg
    import pwm_dither_pkg::*;
#(
    parameter int FRAC_W  = DEF_FRAC_W,
    parameter int DEPTH_W = DEF_DEPTH_W,
    localparam int SH_W   = $clog2(FRAC_W + 1)
) (
    input  logic [DEPTH_W-1:0] depth_req,
    input  logic [FRAC_W-1:0]  frac_in,
    input  logic               steady_en,
    input  logic               ramping,
    output logic [FRAC_W-1:0]  depth_mask,
    output logic [FRAC_W-1:0]  frac_eff,
    output logic [SH_W-1:0]    shift_amt,
    output gate_e              gate
);
    int d_eff;

    always_comb begin
        d_eff     = clamp_depth(int'(depth_req), FRAC_W);
        shift_amt = SH_W'(FRAC_W - d_eff);
        frac_eff  = frac_in >> shift_amt;
        for (int i = 0; i < FRAC_W; i++) begin
            depth_mask[i] = (i < d_eff);
        end
        if (d_eff == 0)  gate = GATE_OFF;
        else if (steady_en) gate = GATE_STEADY;
        else if (ramping)   gate = GATE_RAMP;
        else                gate = GATE_OFF;
    end

endmodule

// File: rtl/pwm_dither_frame_ctr.sv
module pwm_dither_frame_ctr #(
    parameter int FRAC_W = pwm_dither_pkg::DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic [FRAC_W-1:0] depth_mask,
    output logic [FRAC_W-1:0] pos,
    output logic [FRAC_W-1:0] pos_rev
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (advance) begin
            pos <= (pos + 1'b1) & depth_mask;
        end
    end

    // Full-width mirror; the low d bits are picked later by shifting
    for (genvar g = 0; g < FRAC_W; g++) begin : g_rev
        assign pos_rev[g] = pos[FRAC_W-1-g];
    end

endmodule

// File: rtl/pwm_dither_extend.sv
module pwm_dither_extend
    import pwm_dither_pkg::*;
#(
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W,
    localparam int SH_W  = $clog2(FRAC_W + 1)
) (
    input  logic [INT_W-1:0]  duty_int,
    input  logic [FRAC_W-1:0] frac_eff,
    input  logic [FRAC_W-1:0] pos_rev,
    input  logic [SH_W-1:0]   shift_amt,
    input  gate_e             gate,
    output logic [INT_W-1:0]  duty_next
);
    logic [FRAC_W-1:0] rank;
    logic              at_full;
    logic              extend;

    always_comb begin
        rank      = pos_rev >> shift_amt;
        at_full   = (duty_int == {INT_W{1'b1}});
        extend    = (gate != GATE_OFF) && (frac_eff > rank) && !at_full;
        duty_next = duty_int + INT_W'(extend);
    end

endmodule

// File: rtl/pwm_dither_unit.sv
module pwm_dither_unit
    import pwm_dither_pkg::*;
#(
    parameter int INT_W   = DEF_INT_W,
    parameter int FRAC_W  = DEF_FRAC_W,
    parameter int DEPTH_W = DEF_DEPTH_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [INT_W+FRAC_W-1:0] duty_ext,
    input  logic                    period_start,
    input  logic [DEPTH_W-1:0]      dither_depth,
    input  logic                    steady_dither_en,
    input  logic                    ramping,
    output logic [INT_W-1:0]        duty_out
);
    localparam int SH_W = $clog2(FRAC_W + 1);

    logic [INT_W-1:0]  duty_int;
    logic [FRAC_W-1:0] frac_in;
    logic [FRAC_W-1:0] depth_mask;
    logic [FRAC_W-1:0] frac_eff;
    logic [SH_W-1:0]   shift_amt;
    gate_e             gate;
    logic [FRAC_W-1:0] frame_pos;
    logic [FRAC_W-1:0] frame_rev;
    logic [INT_W-1:0]  duty_next;

    assign duty_int = duty_ext[INT_W+FRAC_W-1:FRAC_W];
    assign frac_in  = duty_ext[FRAC_W-1:0];

    pwm_dither_cfg #(.FRAC_W(FRAC_W), .DEPTH_W(DEPTH_W)) u_cfg (
        .depth_req (dither_depth),
        .frac_in   (frac_in),
        .steady_en (steady_dither_en),
        .ramping   (ramping),
        .depth_mask(depth_mask),
        .frac_eff  (frac_eff),
        .shift_amt (shift_amt),
        .gate      (gate)
    );

    pwm_dither_frame_ctr #(.FRAC_W(FRAC_W)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .advance   (period_start),
        .depth_mask(depth_mask),
        .pos       (frame_pos),
        .pos_rev   (frame_rev)
    );

    pwm_dither_extend #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_ext (
        .duty_int (duty_int),
        .frac_eff (frac_eff),
        .pos_rev  (frame_rev),
        .shift_amt(shift_amt),
        .gate     (gate),
        .duty_next(duty_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_out <= '0;
        end else if (period_start) begin
            duty_out <= duty_next;
        end
    end

endmodule

// File: rtl/pwm_dither_unit_chk.sv
module pwm_dither_unit_chk #(
    parameter int INT_W   = 10,
    parameter int FRAC_W  = 4,
    parameter int DEPTH_W = 3
) (
    input logic                    clk,
    input logic                    rst,
    input logic [INT_W+FRAC_W-1:0] duty_ext,
    input logic                    period_start,
    input logic [DEPTH_W-1:0]      dither_depth,
    input logic                    steady_dither_en,
    input logic                    ramping,
    input logic [INT_W-1:0]        duty_out,
    input logic [FRAC_W-1:0]       frame_pos,
    input logic [FRAC_W-1:0]       depth_mask
);
    logic [INT_W-1:0] int_now;
    logic [INT_W:0]   int_plus;
    assign int_now  = duty_ext[INT_W+FRAC_W-1:FRAC_W];
    assign int_plus = {1'b0, int_now} + 1'b1;

    // R2
    hold_between_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(period_start) && !$past(rst)) |-> $stable(duty_out));

    // R3
    step_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(period_start) && !$past(rst)) |->
            ((duty_out == $past(int_now)) || ({1'b0, duty_out} == $past(int_plus))));

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(period_start) && !$past(rst) && ($past(int_now) == {INT_W{1'b1}})) |->
            (duty_out == {INT_W{1'b1}}));

    // R9
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(period_start) && !$past(rst) && !$past(steady_dither_en) && !$past(ramping)) |->
            (duty_out == $past(int_now)));

    // R8
    depth_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(period_start) && !$past(rst) && ($past(dither_depth) == '0)) |->
            (duty_out == $past(int_now)));

    // R12
    pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !period_start |=> $stable(frame_pos));

    // R12
    pos_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        period_start |=> ((frame_pos & ~$past(depth_mask)) == '0));

endmodule

bind pwm_dither_unit pwm_dither_unit_chk #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .DEPTH_W(DEPTH_W)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .duty_ext        (duty_ext),
    .period_start    (period_start),
    .dither_depth    (dither_depth),
    .steady_dither_en(steady_dither_en),
    .ramping         (ramping),
    .duty_out        (duty_out),
    .frame_pos       (frame_pos),
    .depth_mask      (depth_mask)
);

// File: tb/pwm_dither_unit_bench.sv
`timescale 1ns/1ps
module pwm_dither_unit_bench;
    localparam int INT_W   = 10;
    localparam int FRAC_W  = 4;
    localparam int DEPTH_W = 3;
    localparam int FULL    = (1 << INT_W) - 1;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [INT_W+FRAC_W-1:0] duty_ext = '0;
    logic                    period_start = 1'b0;
    logic [DEPTH_W-1:0]      dither_depth = '0;
    logic                    steady_dither_en = 1'b0;
    logic                    ramping = 1'b0;
    logic [INT_W-1:0]        duty_out;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    pwm_dither_unit #(.INT_W(INT_W), .FRAC_W(FRAC_W), .DEPTH_W(DEPTH_W)) u_pwm_dither_unit (
        .clk             (clk),
        .rst             (rst),
        .duty_ext        (duty_ext),
        .period_start    (period_start),
        .dither_depth    (dither_depth),
        .steady_dither_en(steady_dither_en),
        .ramping         (ramping),
        .duty_out        (duty_out)
    );

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        period_start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Strobe once; the output is sampled at the following falling edge
    task automatic strobe(int idle, output int val);
        for (int k = 0; k < idle; k++) @(negedge clk);
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
        val = int'(duty_out);
    endtask

    task automatic setup(int depth, bit steady, bit ramp, int ival, int frac);
        do_reset();
        dither_depth     = DEPTH_W'(depth);
        steady_dither_en = steady;
        ramping          = ramp;
        duty_ext         = {INT_W'(ival), FRAC_W'(frac)};
    endtask

    // Sum over n strobes; also checks each value lies in {I, I+1}
    task automatic frame_sum(string tag, int n, int ival, int exp_sum);
        int sum = 0;
        int v;
        int bad = 0;
        for (int k = 0; k < n; k++) begin
            strobe(1 + (k % 3), v);
            sum += v;
            if (v != ival && v != ival + 1) bad++;
        end
        check({tag, " R3 values within I..I+1 (bad count)"}, bad, 0);
        check({tag, " frame sum"}, sum, exp_sum);
    endtask

    // Per-position pattern: bit p of pat set means period p is extended
    task automatic pattern(string tag, int n, int ival, int pat);
        int v;
        for (int k = 0; k < n; k++) begin
            strobe(0, v);
            check($sformatf("%s pos %0d", tag, k), v, ival + ((pat >> k) & 1));
        end
    endtask

    task automatic t_reset();
        setup(1, 1'b1, 1'b0, 5, 8);
        check("R1 duty_out after reset", int'(duty_out), 0);
        pattern("R1 first strobe at position 0", 1, 5, 1);
    endtask

    task automatic t_hold();
        int v;
        setup(0, 1'b0, 1'b0, 33, 0);
        strobe(0, v);
        check("R2 loaded on strobe", v, 33);
        duty_ext = {INT_W'(400), FRAC_W'(3)};
        repeat (6) @(negedge clk);
        check("R2 held without strobe", int'(duty_out), 33);
        strobe(0, v);
        check("R2 reloaded on next strobe", v, 400);
    endtask

    task automatic t_spread();
        setup(1, 1'b1, 1'b0, 5, 8);
        pattern("R5 d1 F1 every second", 4, 5, 'b0101);
        setup(4, 1'b1, 1'b0, 50, 5);
        pattern("R5 d4 F5 bit-reversed", 16, 50, 'h1115);
    endtask

    task automatic t_one_in_eight();
        setup(3, 1'b1, 1'b0, 100, 2);
        pattern("R6 d3 F1 one in eight", 8, 100, 'b0000_0001);
    endtask

    task automatic t_counts();
        // frac 4'b1011 with d=2 keeps top bits 10 -> F=2
        setup(2, 1'b1, 1'b0, 9, 11);
        frame_sum("R4 d2", 4, 9, 4*9 + 2);
        setup(4, 1'b0, 1'b1, 200, 13);
        frame_sum("R4 d4", 16, 200, 16*200 + 13);
    endtask

    task automatic t_clamp();
        setup(6, 1'b1, 1'b0, 7, 11);
        frame_sum("R7 depth 6", 16, 7, 16*7 + 11);
        setup(7, 1'b1, 1'b0, 7, 5);
        pattern("R7 depth 7 as 4", 16, 7, 'h1115);
    endtask

    task automatic t_depth0();
        setup(0, 1'b1, 1'b1, 77, 15);
        frame_sum("R8 depth 0", 8, 77, 8*77);
    endtask

    task automatic t_gating();
        setup(4, 1'b0, 1'b0, 20, 15);
        frame_sum("R9 no ramp no steady", 16, 20, 320);
        setup(4, 1'b0, 1'b1, 20, 15);
        frame_sum("R9 ramping", 16, 20, 335);
        setup(4, 1'b1, 1'b0, 20, 15);
        frame_sum("R10 steady flat", 16, 20, 335);
        setup(4, 1'b1, 1'b1, 20, 15);
        frame_sum("R10 steady ramping", 16, 20, 335);
    endtask

    task automatic t_saturate();
        setup(4, 1'b1, 1'b1, FULL, 15);
        frame_sum("R11 full scale", 16, FULL, 16*FULL);
    endtask

    task automatic t_wrap();
        // d=2, frac 4'b0100 -> F=1: only position 0 of each frame extended
        setup(2, 1'b1, 1'b0, 40, 4);
        pattern("R12 wrap at 4", 9, 40, 'b1_0001_0001);
        setup(2, 1'b1, 1'b0, 40, 4);
        repeat (20) @(negedge clk);
        pattern("R12 idle cycles no advance", 2, 40, 'b01);
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_hold();
        t_spread();
        t_one_in_eight();
        t_counts();
        t_clamp();
        t_depth0();
        t_gating();
        t_saturate();
        t_wrap();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule